// File: doc/BRIEF.md
# Two-Dimensional Reference Pixel Tile Cache

This block sits between the motion-compensation engine of a video decoder and the external frame-buffer memory. It keeps recently used reference-picture pixels on chip so that overlapping prediction blocks, and the several reference pictures a bi-predicted picture draws on, do not make the decoder fetch the same bytes again. Each line holds a rectangle of 8 pixels across by 2 rows of 8-bit samples (128 bits). That is one minimum-length memory burst, so a miss always costs exactly one burst and never fetches a partial line.

A request carries a reference-picture identifier and the pixel position (x, y) of the tile. The low bits x[2:0] and y[0] pick a pixel inside the tile and are ignored. The set is chosen by both horizontal and vertical position bits, so tiles that are neighbours vertically do not compete for the same four ways. On a hit the stored line comes back the cycle after acceptance. On a miss the block issues a single line read, installs the returned line in the set and forwards it. A flush input drops every line at picture boundaries. Two counters record hits and misses, so the bytes fetched can be compared with the ideal bandwidth.

Top module: `pix_tile_cache`

## Requirements
- R1: After reset reqReady is 1, rspValid and memReqValid are 0, and both counters read 0.
- R2: A request whose tile (reference ID, x[10:3], y[10:1]) is resident is answered the cycle after acceptance with rspHit=1 and the stored line, and no memory read is issued. Offset bits x[2:0] and y[0] do not change which tile is addressed.
- R3: The reference ID is part of the match: the same coordinates under another ID are a different tile.
- R4: A miss issues exactly one memory read with line address {ref, y[10:1], x[10:3]}, held stable until memReqReady. reqReady stays 0 from acceptance until the fill. The response comes the cycle after memRspValid, with rspHit=0 and the fetched line.
- R5: The set index is {x[4:3], y[2:1]}, and each set has four ways. Seven tiles spread over four vertical positions and four horizontal positions in the same column group all stay resident together.
- R6: A fill uses an invalid way of the set if there is one. Otherwise it evicts the least recently used way. Hits and fills both count as uses.
- R7: A flush invalidates every line in one cycle, and reqReady is 0 during a flush cycle.
- R8: When flush and a fill fall in the same cycle, the fill's response is still delivered, but the line is not retained.
- R9: hitCount rises by one for each hit and missCount by one for each miss, each counted at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines this cycle |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted |
| reqRef | input | REF_W | Reference picture ID |
| reqX | input | X_W | Horizontal pixel position |
| reqY | input | Y_W | Vertical pixel position |
| rspValid | output | 1 | Response present (one cycle) |
| rspHit | output | 1 | Response was served from storage |
| rspData | output | LINE_W | 8x2 tile, 128 bits |
| memReqValid | output | 1 | Line read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | ADDR_W | Line address of the tile |
| memRspValid | input | 1 | Read data present |
| memRspData | input | LINE_W | Read line data |
| hitCount | output | CNT_W | Hits since reset |
| missCount | output | CNT_W | Misses since reset |

## Verification
The collision of interest is a flush landing in the same cycle as a line fill. The valid bit of the victim way is both set and cleared in that cycle, and the response still has to go out. The bench provokes this by having its memory model raise flush together with memRspValid. The scoreboard then expects a miss response carrying the fetched line, and a second request for the same tile must miss again. A flush while idle is also judged, by seeing reqReady drop in that cycle and previously resident tiles miss afterwards.

// File: rtl/pixcache_pkg.sv
package pixcache_pkg;

  typedef struct packed {
    logic accept;
    logic touch;
    logic fill;
    logic clear;
  } cacheStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ASK,
    ST_WAIT
  } fillState_e;

endpackage

// File: rtl/pixcache_dp.sv
module pixcache_dp
  import pixcache_pkg::*;
#(
  parameter int REF_W      = 2,
  parameter int X_W        = 11,
  parameter int Y_W        = 11,
  parameter int SET_X_W    = 2,
  parameter int SET_Y_W    = 2,
  parameter int WAYS       = 4,
  parameter int PIX_W      = 8,
  parameter int TILE_X_LOG = 3,
  parameter int TILE_Y_LOG = 1,
  localparam int LINE_W    = PIX_W << (TILE_X_LOG + TILE_Y_LOG),
  localparam int ADDR_W    = REF_W + (Y_W - TILE_Y_LOG) + (X_W - TILE_X_LOG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cacheStrobe_t      st,
  input  logic [REF_W-1:0]  reqRef,
  input  logic [X_W-1:0]    reqX,
  input  logic [Y_W-1:0]    reqY,
  input  logic [LINE_W-1:0] memRspData,
  output logic              lookupHit,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [LINE_W-1:0] rspData
);
  localparam int SET_W = SET_X_W + SET_Y_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int TX_W  = X_W - TILE_X_LOG - SET_X_W;
  localparam int TY_W  = Y_W - TILE_Y_LOG - SET_Y_W;
  localparam int TAG_W = REF_W + TX_W + TY_W;

  logic [WAYS-1:0]   validQ [SETS];
  logic [TAG_W-1:0]  tagQ   [SETS][WAYS];
  logic [LINE_W-1:0] dataQ  [SETS][WAYS];
  logic [WAY_W-1:0]  ageQ   [SETS][WAYS];

  logic [REF_W-1:0] curRef;
  logic [X_W-1:0]   curX;
  logic [Y_W-1:0]   curY;

  logic [SET_W-1:0] reqSet, curSet, touchSet;
  logic [TAG_W-1:0] reqTag, curTag;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay, victim, touchWay, touchAge;
  logic             foundFree;

  assign reqSet = {reqX[TILE_X_LOG+SET_X_W-1:TILE_X_LOG], reqY[TILE_Y_LOG+SET_Y_W-1:TILE_Y_LOG]};
  assign curSet = {curX[TILE_X_LOG+SET_X_W-1:TILE_X_LOG], curY[TILE_Y_LOG+SET_Y_W-1:TILE_Y_LOG]};
  assign reqTag = {reqRef, reqX[X_W-1 -: TX_W], reqY[Y_W-1 -: TY_W]};
  assign curTag = {curRef, curX[X_W-1 -: TX_W], curY[Y_W-1 -: TY_W]};
  assign memReqAddr = {curRef, curY[Y_W-1:TILE_Y_LOG], curX[X_W-1:TILE_X_LOG]};

  // one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : gWay
    assign hitVec[w] = validQ[reqSet][w] && (tagQ[reqSet][w] == reqTag);
  end
  assign lookupHit = |hitVec;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) if (hitVec[w]) hitWay = WAY_W'(w);
  end

  // free way first, else the oldest
  always_comb begin
    victim    = '0;
    foundFree = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!foundFree && !validQ[curSet][w]) begin
        victim    = WAY_W'(w);
        foundFree = 1'b1;
      end
    if (!foundFree)
      for (int w = 0; w < WAYS; w++)
        if (ageQ[curSet][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
  end

  assign touchSet = st.touch ? reqSet : curSet;
  assign touchWay = st.touch ? hitWay : victim;
  assign touchAge = ageQ[touchSet][touchWay];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) ageQ[s][w] <= WAY_W'(w);
    end else if (st.touch || st.fill) begin
      for (int w = 0; w < WAYS; w++)
        if (WAY_W'(w) == touchWay) ageQ[touchSet][w] <= '0;
        else if (ageQ[touchSet][w] < touchAge) ageQ[touchSet][w] <= ageQ[touchSet][w] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.clear) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (st.fill) begin
      validQ[curSet][victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.fill) begin
      tagQ[curSet][victim]  <= curTag;
      dataQ[curSet][victim] <= memRspData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRef <= '0;
      curX   <= '0;
      curY   <= '0;
    end else if (st.accept) begin
      curRef <= reqRef;
      curX   <= reqX;
      curY   <= reqY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
    end else begin
      rspValid <= st.touch || st.fill;
      rspHit   <= st.touch;
    end
  end

  always_ff @(posedge clk) begin
    if (st.touch)     rspData <= dataQ[reqSet][hitWay];
    else if (st.fill) rspData <= memRspData;
  end

  // checks
  logic anyValid;
  logic [WAY_W:0] oldestCnt;
  always_comb begin
    anyValid  = 1'b0;
    oldestCnt = '0;
    for (int s = 0; s < SETS; s++) anyValid = anyValid | (|validQ[s]);
    for (int w = 0; w < WAYS; w++)
      if (ageQ[curSet][w] == WAY_W'(WAYS - 1)) oldestCnt = oldestCnt + 1'b1;
  end

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.clear |=> !anyValid);
  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
  assert_lru_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.fill |-> (oldestCnt == 1));
endmodule

// File: rtl/pixcache_ctrl.sv
module pixcache_ctrl
  import pixcache_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              lookupHit,
  output logic              memReqValid,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memReqAddr,
  input  logic              rspValid,
  input  logic              rspHit,
  output cacheStrobe_t      st,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  fillState_e state;

  assign reqReady    = (state == ST_IDLE) && !flush;
  assign memReqValid = (state == ST_ASK);

  always_comb begin
    st        = '0;
    st.accept = reqValid && reqReady;
    st.touch  = st.accept && lookupHit;
    st.fill   = (state == ST_WAIT) && memRspValid;
    st.clear  = flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (st.touch) hitCount <= hitCount + 1'b1;
      if (st.accept && !lookupHit) missCount <= missCount + 1'b1;
      unique case (state)
        ST_IDLE: if (st.accept && !lookupHit) state <= ST_ASK;
        ST_ASK:  if (memReqReady) state <= ST_WAIT;
        ST_WAIT: if (memRspValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hit_answers_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.touch |=> rspValid && rspHit);
  assert_read_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));
  assert_fill_answers_R4: assert property (@(posedge clk) disable iff (!rstN)
    st.fill |=> rspValid && !rspHit);
  assert_hit_counted_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit |-> hitCount == $past(hitCount) + 1'b1);
endmodule

// File: rtl/pix_tile_cache.sv
module pix_tile_cache
  import pixcache_pkg::*;
#(
  parameter int REF_W      = 2,
  parameter int X_W        = 11,
  parameter int Y_W        = 11,
  parameter int SET_X_W    = 2,
  parameter int SET_Y_W    = 2,
  parameter int WAYS       = 4,
  parameter int PIX_W      = 8,
  parameter int TILE_X_LOG = 3,
  parameter int TILE_Y_LOG = 1,
  parameter int CNT_W      = 32,
  localparam int LINE_W    = PIX_W << (TILE_X_LOG + TILE_Y_LOG),
  localparam int ADDR_W    = REF_W + (Y_W - TILE_Y_LOG) + (X_W - TILE_X_LOG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [REF_W-1:0]  reqRef,
  input  logic [X_W-1:0]    reqX,
  input  logic [Y_W-1:0]    reqY,
  output logic              rspValid,
  output logic              rspHit,
  output logic [LINE_W-1:0] rspData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [LINE_W-1:0] memRspData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  cacheStrobe_t st;
  logic lookupHit;

  pixcache_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqReady(reqReady),
    .lookupHit(lookupHit), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memReqAddr(memReqAddr), .rspValid(rspValid),
    .rspHit(rspHit), .st(st), .hitCount(hitCount), .missCount(missCount)
  );

  pixcache_dp #(
    .REF_W(REF_W), .X_W(X_W), .Y_W(Y_W), .SET_X_W(SET_X_W), .SET_Y_W(SET_Y_W),
    .WAYS(WAYS), .PIX_W(PIX_W), .TILE_X_LOG(TILE_X_LOG), .TILE_Y_LOG(TILE_Y_LOG)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .reqRef(reqRef), .reqX(reqX), .reqY(reqY),
    .memRspData(memRspData), .lookupHit(lookupHit), .memReqAddr(memReqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData)
  );
endmodule

// File: tb/sim_pix_tile_cache.sv
module sim_pix_tile_cache;
  localparam int REF_W = 2, X_W = 11, Y_W = 11, LINE_W = 128, ADDR_W = 20, CNT_W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rstN = 1'b0, flush = 1'b0, reqValid = 1'b0, reqReady;
  logic [REF_W-1:0] reqRef = '0;
  logic [X_W-1:0] reqX = '0;
  logic [Y_W-1:0] reqY = '0;
  logic rspValid, rspHit, memReqValid, memRspValid = 1'b0;
  logic memReqReady = 1'b1;
  logic [LINE_W-1:0] rspData, memRspData = '0;
  logic [ADDR_W-1:0] memReqAddr;
  logic [CNT_W-1:0] hitCount, missCount;

  pix_tile_cache u0 (.*);

  int checks = 0, fails = 0, expHits = 0, expMisses = 0, fetches = 0;
  bit done = 1'b0;

  typedef struct { logic hit; logic [LINE_W-1:0] data; string req; } exp_t;
  exp_t expQ[$];
  logic [ADDR_W-1:0] addrQ[$];

  function automatic logic [LINE_W-1:0] lineOf(logic [ADDR_W-1:0] a);
    return {a, 12'h1A1, a, 12'h2B2, a, 12'h3C3, a, 12'h4D4};
  endfunction

  function automatic logic [ADDR_W-1:0] lineAddr(logic [REF_W-1:0] r, logic [X_W-1:0] x, logic [Y_W-1:0] y);
    return {r, y[Y_W-1:1], x[X_W-1:3]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one request, expectation pushed to the scoreboard
  task automatic sendReq(int r, int x, int y, bit expHit, string req);
    exp_t e;
    logic [ADDR_W-1:0] a;
    @(negedge clk); #1;
    while (!reqReady) begin @(negedge clk); #1; end
    a = lineAddr(REF_W'(r), X_W'(x), Y_W'(y));
    reqValid = 1'b1; reqRef = REF_W'(r); reqX = X_W'(x); reqY = Y_W'(y);
    e.hit = expHit; e.data = lineOf(a); e.req = req;
    expQ.push_back(e);
    if (expHit) expHits++;
    else begin expMisses++; addrQ.push_back(a); end
    @(negedge clk); #1;
    reqValid = 1'b0;
    if (expHit) check(reqReady && !memReqValid, "R2", "no read on hit", {reqReady, memReqValid}, 2'b10);
    else check(!reqReady && memReqValid, "R4", "busy with read after miss", {reqReady, memReqValid}, 2'b01);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rspValid) begin
      if (expQ.size() == 0) check(1'b0, "R2", "unexpected response", rspData, '0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        check(rspHit == e.hit, e.req, "hit flag", rspHit, e.hit);
        check(rspData == e.data, e.req, "line data", rspData, e.data);
      end
    end
  end

  // memory model with optional flush on the fill cycle
  bit flushNow = 1'b0, flushOnRsp = 1'b0;
  int cnt = 0;
  logic [ADDR_W-1:0] pendAddr = '0;
  always @(negedge clk) begin
    logic rsp;
    rsp = 1'b0;
    memRspValid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        rsp = 1'b1;
        memRspValid = 1'b1;
        memRspData = lineOf(pendAddr);
      end
    end
    flush = flushNow || (rsp && flushOnRsp);
    if (rsp) flushOnRsp = 1'b0;
    flushNow = 1'b0;
    if (memReqValid && cnt == 0) begin
      fetches++;
      pendAddr = memReqAddr;
      cnt = 3;
      if (addrQ.size() == 0) check(1'b0, "R4", "extra read", memReqAddr, '0);
      else begin
        logic [ADDR_W-1:0] ea;
        ea = addrQ.pop_front();
        check(memReqAddr == ea, "R4", "read line address", memReqAddr, ea);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(reqReady && !rspValid && !memReqValid, "R1", "reset outputs",
          {reqReady, rspValid, memReqValid}, 3'b100);
    check(hitCount == 0 && missCount == 0, "R1", "reset counters", {hitCount, missCount}, '0);

    // R2, R3: basic hit/miss, offsets ignored, ref ID matters
    sendReq(0, 0, 0, 0, "R4");
    sendReq(0, 5, 1, 1, "R2");
    sendReq(1, 0, 0, 0, "R3");
    sendReq(0, 0, 0, 1, "R3");
    sendReq(1, 7, 1, 1, "R3");

    // R6: one set (x[4:3]=01, y=0): fill four, then LRU eviction
    sendReq(0, 8, 0, 0, "R6");
    sendReq(0, 40, 0, 0, "R6");
    sendReq(0, 72, 0, 0, "R6");
    sendReq(0, 104, 0, 0, "R6");
    sendReq(0, 8, 0, 1, "R6");
    sendReq(0, 136, 0, 0, "R6");   // evicts 40
    sendReq(0, 8, 0, 1, "R6");
    sendReq(0, 72, 0, 1, "R6");
    sendReq(0, 104, 0, 1, "R6");
    sendReq(0, 40, 0, 0, "R6");    // evicts 136
    sendReq(0, 136, 0, 0, "R6");   // evicts 8
    sendReq(0, 40, 0, 1, "R6");
    sendReq(0, 104, 0, 1, "R6");
    sendReq(0, 72, 0, 1, "R6");
    sendReq(0, 8, 0, 0, "R6");     // evicts 136
    sendReq(0, 8, 2, 0, "R5");     // other set via y[2:1]
    sendReq(0, 8, 0, 1, "R5");
    sendReq(0, 40, 0, 1, "R5");
    sendReq(0, 72, 0, 1, "R5");
    sendReq(0, 104, 0, 1, "R5");
    drain();

    // R7: idle flush
    @(negedge clk); #1;
    flushNow = 1'b1;
    @(negedge clk); #1;
    check(!reqReady, "R7", "reqReady low during flush", reqReady, 1'b0);
    sendReq(0, 8, 0, 0, "R7");
    sendReq(0, 0, 0, 0, "R7");

    // R5: 2-D index keeps seven tiles resident
    for (int i = 0; i < 4; i++) sendReq(0, 16 + 32 * i, 0, 0, "R5");
    for (int j = 1; j < 4; j++) sendReq(0, 16, 2 * j, 0, "R5");
    for (int i = 0; i < 4; i++) sendReq(0, 16 + 32 * i, 0, 1, "R5");
    for (int j = 1; j < 4; j++) sendReq(0, 17, 2 * j + 1, 1, "R5");
    drain();

    // R8: flush in the same cycle as the fill
    flushOnRsp = 1'b1;
    sendReq(2, 200, 20, 0, "R8");
    sendReq(2, 200, 20, 0, "R8");
    sendReq(2, 203, 21, 1, "R8");
    sendReq(0, 16, 0, 0, "R8");
    drain();

    // R9: counters and fetch count
    check(hitCount == CNT_W'(expHits), "R9", "hit counter", hitCount, expHits);
    check(missCount == CNT_W'(expMisses), "R9", "miss counter", missCount, expMisses);
    check(fetches == expMisses, "R4", "one read per miss", fetches, expMisses);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule